// File: doc/BRIEF.md
# Longest Prefix Match Lookup

This block makes the forwarding decision for IPv4 packets. It keeps a small table of routes. Each route has a valid flag, a route prefix, a prefix length from 0 to 32 and an output port. When a 32-bit destination address is presented, every valid route is compared against it in parallel. A reduction stage then picks, among the routes that match, the one with the longest prefix. Its output port is returned one clock later, together with a hit flag. A result without a hit tells the caller to drop the packet.

Routes are written one entry at a time through a configuration port that carries an index. A route of length zero matches every address, so it serves as the default route. Routes are removed by writing them with the valid flag cleared.

Top module: `lpm_lookup`

## Requirements
- R1: After reset, rsp_valid_o, rsp_hit_o and rsp_port_o are all 0, and every route is invalid, so any lookup misses.
- R2: A cycle with cfg_we_i high stores cfg_valid_i, cfg_prefix_i, cfg_len_i and cfg_port_i at entry cfg_idx_i. Lookups requested from the following cycle onward see the new route. A lookup in the same cycle as the write uses the old contents.
- R3: A valid route of length L matches an address when the L most significant bits of the address equal the L most significant bits of the stored prefix. The lower 32-L bits of the stored prefix are ignored.
- R4: When several routes match, the result is the port of the matching route with the greatest length.
- R5: When no route matches, rsp_hit_o is 0 and rsp_port_o is 0.
- R6: A valid route of length 0 matches every address.
- R7: When matching routes share the greatest length, the one with the lowest index wins.
- R8: An entry written with the valid flag at 0 never matches.
- R9: A written length above 32 is stored as 32. It then ranks equal to, not above, other /32 routes.
- R10: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. Otherwise it is low. rsp_hit_o and rsp_port_o change only in response to a request and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Route write strobe |
| cfg_idx_i | input | IDX_W (4) | Entry index to write |
| cfg_valid_i | input | 1 | Valid flag for the written route |
| cfg_prefix_i | input | 32 | Route prefix |
| cfg_len_i | input | 6 | Prefix length (0 to 32; larger values are clamped) |
| cfg_port_i | input | PORT_W (4) | Output port of the route |
| req_valid_i | input | 1 | Lookup request strobe |
| req_addr_i | input | 32 | Destination address to look up |
| rsp_valid_o | output | 1 | Result strobe, one cycle after a request |
| rsp_hit_o | output | 1 | A route matched |
| rsp_port_o | output | PORT_W (4) | Output port of the winning route, 0 on a miss |

## Verification
The assertions check the response protocol on every cycle. A result strobe follows each request and only a request. A miss always carries port 0. Hit and port hold steady while no request is made. Which route wins depends on the table contents, so only the bench scenarios can show it. These scenarios cover longest-length priority over nested prefixes, the default route, the lower-index tie rule with differing don't-care bits, invalidation, length clamping, and the old-contents result of a write that lands in the same cycle as a lookup.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = $clog2(ADDR_W + 1);

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] prefix;
    logic [LEN_W-1:0]  len;
  } route_t;

  // ones in the len most significant bits
  function automatic logic [ADDR_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] ones;
    ones = '1;
    if (int'(len) >= ADDR_W) return ones;
    return ~(ones >> len);
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] prefix_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PORT_W-1:0] port_i,
  output route_t            routes_o [N_ENTRIES],
  output logic [PORT_W-1:0] ports_o  [N_ENTRIES]
);
  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    len_clamped = len_i;
    if (int'(len_i) > ADDR_W) len_clamped = LEN_W'(ADDR_W);
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        routes_o[g] <= '0;
        ports_o[g]  <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        routes_o[g].valid  <= valid_i;
        routes_o[g].prefix <= prefix_i;
        routes_o[g].len    <= len_clamped;
        ports_o[g]         <= port_i;
      end
    end
  end
endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  route_t               routes_i [N_ENTRIES],
  output logic [N_ENTRIES-1:0] match_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] diff;
    assign diff       = (addr_i ^ routes_i[g].prefix) & prefix_mask(routes_i[g].len);
    assign match_o[g] = routes_i[g].valid && (diff == '0);
  end
endmodule

// File: rtl/lpm_select.sv
module lpm_select
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] match_i,
  input  route_t               routes_i [N_ENTRIES],
  input  logic [PORT_W-1:0]    ports_i  [N_ENTRIES],
  output logic                 hit_o,
  output logic [PORT_W-1:0]    port_o
);
  logic [LEN_W-1:0] best_len;
  logic [IDX_W-1:0] best_idx;

  // strict greater-than keeps the lowest index on equal length
  always_comb begin
    hit_o    = 1'b0;
    best_len = '0;
    best_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match_i[i] && (!hit_o || (routes_i[i].len > best_len))) begin
        hit_o    = 1'b1;
        best_len = routes_i[i].len;
        best_idx = IDX_W'(i);
      end
    end
    port_o = hit_o ? ports_i[best_idx] : '0;
  end
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [31:0]       cfg_prefix_i,
  input  logic [5:0]        cfg_len_i,
  input  logic [PORT_W-1:0] cfg_port_i,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PORT_W-1:0] rsp_port_o
);
  route_t               routes [N_ENTRIES];
  logic [PORT_W-1:0]    ports  [N_ENTRIES];
  logic [N_ENTRIES-1:0] match;
  logic                 sel_hit;
  logic [PORT_W-1:0]    sel_port;

  lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .idx_i    (cfg_idx_i),
    .valid_i  (cfg_valid_i),
    .prefix_i (cfg_prefix_i),
    .len_i    (cfg_len_i),
    .port_i   (cfg_port_i),
    .routes_o (routes),
    .ports_o  (ports)
  );

  lpm_match #(.N_ENTRIES(N_ENTRIES)) i_match (
    .addr_i   (req_addr_i),
    .routes_i (routes),
    .match_o  (match)
  );

  lpm_select #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) i_select (
    .match_i  (match),
    .routes_i (routes),
    .ports_i  (ports),
    .hit_o    (sel_hit),
    .port_o   (sel_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_port_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o  <= sel_hit;
        rsp_port_o <= sel_port;
      end
    end
  end
endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [PORT_W-1:0] rsp_port_o
);
  a_r10_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r10_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(rsp_hit_o) && $stable(rsp_port_o)));

  a_r5_miss_port_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_port_o == '0));
endmodule

bind lpm_lookup lpm_lookup_chk #(.PORT_W(PORT_W)) i_lpm_lookup_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_port_o  (rsp_port_o)
);

// File: tb/test_lpm_lookup.sv
`timescale 1ns/1ps
module test_lpm_lookup;
  localparam int N_ENTRIES = 16;
  localparam int PORT_W    = 4;
  localparam int IDX_W     = $clog2(N_ENTRIES);

  typedef struct packed {
    logic [31:0]       addr;
    logic              hit;
    logic [PORT_W-1:0] port;
  } vec_t;

  // routes: 128.32.0.0/16->1, 128.32.239.0/24->7, 128.32.239.3/32->3
  localparam int N_VEC = 7;
  localparam vec_t VECS [N_VEC] = '{
    '{32'h8020_EF03, 1'b1, 4'd3},
    '{32'h8020_EF05, 1'b1, 4'd7},
    '{32'h8020_0101, 1'b1, 4'd1},
    '{32'h8020_EF02, 1'b1, 4'd7},
    '{32'h8020_FFFF, 1'b1, 4'd1},
    '{32'h0A00_0001, 1'b0, 4'd0},
    '{32'h8021_0000, 1'b0, 4'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic              cfg_valid = 1'b0;
  logic [31:0]       cfg_prefix = '0;
  logic [5:0]        cfg_len = '0;
  logic [PORT_W-1:0] cfg_port = '0;
  logic              req_valid = 1'b0;
  logic [31:0]       req_addr = '0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [PORT_W-1:0] rsp_port;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_lookup #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) i_lpm_lookup (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_idx_i    (cfg_idx),
    .cfg_valid_i  (cfg_valid),
    .cfg_prefix_i (cfg_prefix),
    .cfg_len_i    (cfg_len),
    .cfg_port_i   (cfg_port),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .rsp_valid_o  (rsp_valid),
    .rsp_hit_o    (rsp_hit),
    .rsp_port_o   (rsp_port)
  );

  task automatic check(input string req, input logic v, input logic h,
                       input logic [PORT_W-1:0] p);
    n_checks++;
    if (rsp_valid !== v || rsp_hit !== h || rsp_port !== p) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b hit=%0b port=%0d, expected valid=%0b hit=%0b port=%0d",
               req, rsp_valid, rsp_hit, rsp_port, v, h, p);
    end
  endtask

  task automatic write_route(input int idx, input logic v, input logic [31:0] pfx,
                             input logic [5:0] len, input logic [PORT_W-1:0] port);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_prefix = pfx; cfg_len = len; cfg_port = port;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 1'b0, 4'd0);
    rst_n = 1'b1;
    lookup(32'h8020_EF03);
    check("R1 empty table misses", 1'b1, 1'b0, 4'd0);

    write_route(5, 1'b1, 32'h8020_0000, 6'd16, 4'd1);
    write_route(2, 1'b1, 32'h8020_EF00, 6'd24, 4'd7);
    write_route(9, 1'b1, 32'h8020_EF03, 6'd32, 4'd3);

    // R4 nested prefixes, R5 misses
    for (int i = 0; i < N_VEC; i++) begin
      lookup(VECS[i].addr);
      check(VECS[i].hit ? "R4 longest prefix" : "R5 miss", 1'b1, VECS[i].hit, VECS[i].port);
    end

    // R10 idle cycle: no strobe, result held
    @(negedge clk);
    check("R10 hold while idle", 1'b0, 1'b0, 4'd0);
    lookup(32'h8020_EF05);
    @(negedge clk);
    check("R10 hold after hit", 1'b0, 1'b1, 4'd7);

    // R6 default route
    write_route(15, 1'b1, 32'hDEAD_BEEF, 6'd0, 4'd9);
    lookup(32'h0A00_0001);
    check("R6 default route", 1'b1, 1'b1, 4'd9);
    lookup(32'h8020_EF03);
    check("R4 /32 beats default", 1'b1, 1'b1, 4'd3);

    // R2 same-cycle write and lookup sees old table
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd7; cfg_valid = 1'b1;
    cfg_prefix = 32'h0A00_0000; cfg_len = 6'd8; cfg_port = 4'd8;
    req_valid = 1'b1; req_addr = 32'h0A00_0001;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R2 same-cycle write uses old route", 1'b1, 1'b1, 4'd9);
    lookup(32'h0A00_0001);
    check("R2 write visible next cycle", 1'b1, 1'b1, 4'd8);

    // R7 tie: idx 11 has garbage low bits (R3), still wins over idx 12
    write_route(12, 1'b1, 32'h0A01_0000, 6'd16, 4'd4);
    write_route(11, 1'b1, 32'h0A01_4D4D, 6'd16, 4'd6);
    lookup(32'h0A01_0203);
    check("R7 tie lower index wins, R3 low bits ignored", 1'b1, 1'b1, 4'd6);

    // R8 invalidate the /32
    write_route(9, 1'b0, 32'h8020_EF03, 6'd32, 4'd3);
    lookup(32'h8020_EF03);
    check("R8 invalid entry ignored", 1'b1, 1'b1, 4'd7);

    // R9 length 40 clamps to 32, ties with /32 at lower index
    write_route(1, 1'b1, 32'hC0A8_0101, 6'd32, 4'd5);
    write_route(3, 1'b1, 32'hC0A8_0101, 6'd40, 4'd2);
    lookup(32'hC0A8_0101);
    check("R9 clamped length ties", 1'b1, 1'b1, 4'd5);
    lookup(32'hC0A8_0100);
    check("R9 clamped entry exact only", 1'b1, 1'b1, 4'd9);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
    end
  end
endmodule